// File: doc/BRIEF.md
# Memory-Resident Block Transfer Sequencer

This block moves a block of 12-bit words between a peripheral and main memory without holding its own transfer counters. The word count and the current address live in two fixed words of main memory. Software primes the count word with the negative of the block length and the address word with one less than the first target location. The sequencer loads both when started, runs the block word by word, stores both back, and signals completion.

For each word the sequencer first bumps the count and the address by one, with both wrapping modulo 4096. It then moves the word in the selected direction. The last word is the one whose bumped count reaches zero. In the device-to-memory direction, a word taken from the device is written to memory at the current address. In the memory-to-device direction, the word at the current address is read and handed to the device.

Every memory and device exchange is a request held until its acknowledge arrives, so the block works with any memory or device latency.

Top module: `dbrk_engine`

## Requirements
- R1: After reset the block is idle: `busy`, `done_flag`, `mem_rd_req`, `mem_wr_req` and `dev_req` are all 0, and no request is raised while `busy` is 0.
- R2: A start pulse while idle is followed by a read of the count word at octal 7750 (`CNT_LOC`), then a read of the address word at octal 7751 (`CNT_LOC`+1), before any data access.
- R3: With `dir_to_mem`=1, the k-th word accepted from the device (k=1..n) is written to memory address (A+k) mod 4096, where A is the value loaded from octal 7751.
- R4: With `dir_to_mem`=0, the k-th word offered on `dev_rdata` is the memory word at (A+k) mod 4096.
- R5: A loaded count C moves n=(4096−C) mod 4096 words, where a count of 0 moves 4096 words. The count is raised by one before each word, and the word that brings it to 0 is the last.
- R6: After the last word, the block writes 0 to octal 7750 and then (A+n) mod 4096 to octal 7751. These are the final two memory accesses of the run.
- R7: `done_flag` is set in the cycle the block returns to idle and stays set until `done_clr` is high at a clock edge. If setting and clearing fall on the same edge, the set wins.
- R8: A start pulse while `busy` is 1 is ignored: the running transfer keeps its direction and length.
- R9: `mem_rd_req` and `mem_wr_req` are never high together. A raised request keeps its address, write data and kind unchanged until the cycle after `mem_done`.
- R10: Address arithmetic wraps, so a block that starts near octal 7777 continues at address 0.
- R11: `busy` rises the cycle after an accepted start. It falls in the same cycle `done_flag` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block transfer when idle |
| dir_to_mem | input | 1 | 1: device to memory, 0: memory to device (sampled with start) |
| done_clr | input | 1 | Clears the done flag |
| mem_addr | output | 12 | Memory address of the current request |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid with mem_done |
| mem_rd_req | output | 1 | Memory read request, held until mem_done |
| mem_wr_req | output | 1 | Memory write request, held until mem_done |
| mem_done | input | 1 | Memory access complete |
| dev_req | output | 1 | Word exchange request to the device, held until dev_ack |
| dev_ack | input | 1 | Device accepts or supplies a word |
| dev_wdata | input | 12 | Word from the device (device-to-memory) |
| dev_rdata | output | 12 | Word for the device (memory-to-device) |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Sticky completion / interrupt flag |

## Verification
Blocks are run in both directions with lengths of 1, 5 and 7 words, and with a count of 0 that sweeps all 4096 addresses. Comparing these shows whether the length comes from the two's-complement count, and whether the zero count is taken as the full memory rather than as empty. A block starting at octal 7775 tells correct modulo-4096 address wrap apart from an overflow. Memory and device latencies rotate between 0 and 2 cycles, which exposes any state that advances without its handshake. Start pulses with the opposite direction are injected during a run. Runs with `done_clr` held high, and runs with `done_clr` left low, separate a sticky flag with set priority from one that clears itself or loses the race.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;

    parameter int unsigned DB_W = 12;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_LD_CNT,
        PH_LD_ADR,
        PH_STEP,
        PH_DEV_GET,
        PH_MEM_WR,
        PH_MEM_RD,
        PH_DEV_PUT,
        PH_WB_CNT,
        PH_WB_ADR
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic               to_mem;
        logic               last;
        logic               flag;
        logic [DB_W-1:0]    cnt;
        logic [DB_W-1:0]    adr;
        logic [DB_W-1:0]    data;
    } eng_t;

endpackage

// File: rtl/dbrk_inc.sv
module dbrk_inc #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    logic [W:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i]       = a[i] ^ carry[i];
        assign carry[i+1] = a[i] & carry[i];
    end
endmodule

// File: rtl/dbrk_ctrl.sv
module dbrk_ctrl
    import dbrk_pkg::*;
#(
    parameter logic [DB_W-1:0] CNT_LOC = 12'o7750
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_to_mem,
    input  logic             done_clr,
    input  logic [DB_W-1:0]  mem_rdata,
    input  logic             mem_done,
    input  logic             dev_ack,
    input  logic [DB_W-1:0]  dev_wdata,
    input  logic [DB_W-1:0]  cnt_inc,
    input  logic [DB_W-1:0]  adr_inc,
    output logic [DB_W-1:0]  cnt_cur,
    output logic [DB_W-1:0]  adr_cur,
    output logic [DB_W-1:0]  mem_addr,
    output logic [DB_W-1:0]  mem_wdata,
    output logic             mem_rd_req,
    output logic             mem_wr_req,
    output logic             dev_req,
    output logic [DB_W-1:0]  dev_rdata,
    output logic             busy,
    output logic             done_flag
);
    localparam logic [DB_W-1:0] ADR_LOC = CNT_LOC + 1'b1;
    localparam eng_t            ENG_RST = '{phase: PH_IDLE, to_mem: 1'b0,
                                            last: 1'b0, flag: 1'b0,
                                            cnt: '0, adr: '0, data: '0};

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        if (done_clr) begin
            eng_d.flag = 1'b0;
        end
        unique case (eng_q.phase)
            PH_IDLE: begin
                if (start) begin
                    eng_d.phase  = PH_LD_CNT;
                    eng_d.to_mem = dir_to_mem;
                end
            end
            PH_LD_CNT: begin
                if (mem_done) begin
                    eng_d.cnt   = mem_rdata;
                    eng_d.phase = PH_LD_ADR;
                end
            end
            PH_LD_ADR: begin
                if (mem_done) begin
                    eng_d.adr   = mem_rdata;
                    eng_d.phase = PH_STEP;
                end
            end
            PH_STEP: begin
                eng_d.cnt   = cnt_inc;
                eng_d.adr   = adr_inc;
                eng_d.last  = (cnt_inc == '0);
                eng_d.phase = eng_q.to_mem ? PH_DEV_GET : PH_MEM_RD;
            end
            PH_DEV_GET: begin
                if (dev_ack) begin
                    eng_d.data  = dev_wdata;
                    eng_d.phase = PH_MEM_WR;
                end
            end
            PH_MEM_WR: begin
                if (mem_done) begin
                    eng_d.phase = eng_q.last ? PH_WB_CNT : PH_STEP;
                end
            end
            PH_MEM_RD: begin
                if (mem_done) begin
                    eng_d.data  = mem_rdata;
                    eng_d.phase = PH_DEV_PUT;
                end
            end
            PH_DEV_PUT: begin
                if (dev_ack) begin
                    eng_d.phase = eng_q.last ? PH_WB_CNT : PH_STEP;
                end
            end
            PH_WB_CNT: begin
                if (mem_done) begin
                    eng_d.phase = PH_WB_ADR;
                end
            end
            PH_WB_ADR: begin
                if (mem_done) begin
                    eng_d.phase = PH_IDLE;
                    eng_d.flag  = 1'b1;
                end
            end
            default: eng_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= ENG_RST;
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        mem_addr   = eng_q.adr;
        mem_wdata  = eng_q.data;
        mem_rd_req = 1'b0;
        mem_wr_req = 1'b0;
        dev_req    = 1'b0;
        unique case (eng_q.phase)
            PH_LD_CNT: begin
                mem_addr   = CNT_LOC;
                mem_rd_req = 1'b1;
            end
            PH_LD_ADR: begin
                mem_addr   = ADR_LOC;
                mem_rd_req = 1'b1;
            end
            PH_MEM_RD:  mem_rd_req = 1'b1;
            PH_MEM_WR:  mem_wr_req = 1'b1;
            PH_DEV_GET: dev_req    = 1'b1;
            PH_DEV_PUT: dev_req    = 1'b1;
            PH_WB_CNT: begin
                mem_addr   = CNT_LOC;
                mem_wdata  = eng_q.cnt;
                mem_wr_req = 1'b1;
            end
            PH_WB_ADR: begin
                mem_addr   = ADR_LOC;
                mem_wdata  = eng_q.adr;
                mem_wr_req = 1'b1;
            end
            default: ;
        endcase
    end

    assign dev_rdata = eng_q.data;
    assign busy      = (eng_q.phase != PH_IDLE);
    assign done_flag = eng_q.flag;
    assign cnt_cur   = eng_q.cnt;
    assign adr_cur   = eng_q.adr;
endmodule

// File: rtl/dbrk_engine.sv
module dbrk_engine
    import dbrk_pkg::*;
#(
    parameter logic [DB_W-1:0] CNT_LOC = 12'o7750
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_to_mem,
    input  logic             done_clr,
    output logic [DB_W-1:0]  mem_addr,
    output logic [DB_W-1:0]  mem_wdata,
    input  logic [DB_W-1:0]  mem_rdata,
    output logic             mem_rd_req,
    output logic             mem_wr_req,
    input  logic             mem_done,
    output logic             dev_req,
    input  logic             dev_ack,
    input  logic [DB_W-1:0]  dev_wdata,
    output logic [DB_W-1:0]  dev_rdata,
    output logic             busy,
    output logic             done_flag
);
    logic [DB_W-1:0] cnt_cur, adr_cur, cnt_inc, adr_inc;

    dbrk_inc #(.W(DB_W)) u_cnt_inc (.a(cnt_cur), .y(cnt_inc));
    dbrk_inc #(.W(DB_W)) u_adr_inc (.a(adr_cur), .y(adr_inc));

    dbrk_ctrl #(.CNT_LOC(CNT_LOC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dir_to_mem (dir_to_mem),
        .done_clr   (done_clr),
        .mem_rdata  (mem_rdata),
        .mem_done   (mem_done),
        .dev_ack    (dev_ack),
        .dev_wdata  (dev_wdata),
        .cnt_inc    (cnt_inc),
        .adr_inc    (adr_inc),
        .cnt_cur    (cnt_cur),
        .adr_cur    (adr_cur),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rd_req (mem_rd_req),
        .mem_wr_req (mem_wr_req),
        .dev_req    (dev_req),
        .dev_rdata  (dev_rdata),
        .busy       (busy),
        .done_flag  (done_flag)
    );
endmodule

// File: rtl/dbrk_engine_chk.sv
module dbrk_engine_chk
    import dbrk_pkg::*;
#(
    parameter logic [DB_W-1:0] CNT_LOC = 12'o7750
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_clr,
    input logic [DB_W-1:0]  mem_addr,
    input logic [DB_W-1:0]  mem_wdata,
    input logic             mem_rd_req,
    input logic             mem_wr_req,
    input logic             mem_done,
    input logic             dev_req,
    input logic             busy,
    input logic             done_flag
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_req && !mem_wr_req && !dev_req));

    a_r9_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_req || mem_wr_req) && !mem_done) |=>
        ($stable(mem_addr) && $stable(mem_wdata) &&
         $stable(mem_rd_req) && $stable(mem_wr_req)));

    a_r2_count_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_rd_req && mem_addr == CNT_LOC));

    a_r11_flag_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !done_clr) |=> done_flag);
endmodule

bind dbrk_engine dbrk_engine_chk #(.CNT_LOC(CNT_LOC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_clr   (done_clr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req),
    .mem_done   (mem_done),
    .dev_req    (dev_req),
    .busy       (busy),
    .done_flag  (done_flag)
);

// File: tb/dbrk_engine_test.sv
module dbrk_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] LOC_C = 12'o7750;
    localparam logic [11:0] LOC_A = 12'o7751;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_to_mem = 1'b0, done_clr = 1'b0;
    logic [11:0] mem_addr, mem_wdata, dev_rdata;
    logic [11:0] mem_rdata = '0, dev_wdata = '0;
    logic        mem_rd_req, mem_wr_req, dev_req, busy, done_flag;
    logic        mem_done = 1'b0, dev_ack = 1'b0;

    int vectors = 0, miscompares = 0;

    logic [11:0] mem [4096];
    int          mem_wait = 0, mem_seed = 0, dev_wait = 0, dev_seed = 1;
    int          n_acc = 0, k = 0;
    logic [11:0] acc0_a, acc1_a, wprev_a, wlast_a;
    logic        acc0_w, acc1_w;
    logic        run_to_mem = 1'b0;
    logic [11:0] cur_cnt = '0, cur_adr = '0;

    dbrk_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_to_mem(dir_to_mem),
        .done_clr(done_clr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_done(mem_done), .dev_req(dev_req), .dev_ack(dev_ack),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .busy(busy),
        .done_flag(done_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] init_val(logic [11:0] a);
        return 12'(a * 5 + 3);
    endfunction

    function automatic logic [11:0] pat(int i);
        return 12'(i * 291 + 17);
    endfunction

    function automatic logic [11:0] exp_mem(logic [11:0] a);
        if (a == LOC_C) return cur_cnt;
        if (a == LOC_A) return cur_adr;
        return init_val(a);
    endfunction

    task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %o expected %o", req, act, exp);
        end
    endtask

    // memory and device models, acting on the falling edge
    always @(negedge clk) begin
        if (mem_done) begin
            mem_done = 1'b0;
        end else if (mem_rd_req || mem_wr_req) begin
            if (mem_wait > 0) begin
                mem_wait--;
            end else begin
                if (n_acc == 0) begin acc0_a = mem_addr; acc0_w = mem_wr_req; end
                if (n_acc == 1) begin acc1_a = mem_addr; acc1_w = mem_wr_req; end
                if (mem_wr_req) begin
                    mem[mem_addr] = mem_wdata;
                    wprev_a = wlast_a;
                    wlast_a = mem_addr;
                end else begin
                    mem_rdata = mem[mem_addr];
                end
                n_acc++;
                mem_done = 1'b1;
                mem_seed++;
                mem_wait = mem_seed % 3;
            end
        end
        if (dev_ack) begin
            dev_ack = 1'b0;
        end else if (dev_req) begin
            if (dev_wait > 0) begin
                dev_wait--;
            end else begin
                k++;
                if (run_to_mem) dev_wdata = pat(k);
                else chk("R4 word to device", dev_rdata, exp_mem(12'(cur_adr + k)));
                dev_ack = 1'b1;
                dev_seed++;
                dev_wait = (dev_seed * 2) % 3;
            end
        end
    end

    task automatic run(logic to_mem, logic [11:0] cnt, logic [11:0] adr,
                       logic disturb, logic hold_clr);
        int n;
        n = (cnt == 0) ? 4096 : 4096 - int'(cnt);
        for (int i = 0; i < 4096; i++) mem[i] = init_val(12'(i));
        mem[LOC_C] = cnt;
        mem[LOC_A] = adr;
        cur_cnt = cnt; cur_adr = adr; run_to_mem = to_mem;
        n_acc = 0; k = 0;
        @(negedge clk);
        dir_to_mem = to_mem; start = 1'b1; done_clr = hold_clr;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", {11'b0, busy}, 12'd1);
        if (disturb) begin
            for (int j = 0; j < 6; j++) begin
                dir_to_mem = ~to_mem; start = 1'b1;
                @(negedge clk);
            end
            start = 1'b0;
        end
        while (!done_flag) @(negedge clk);
        chk("R7 flag set on finish", {11'b0, done_flag}, 12'd1);
        chk("R11 idle with flag", {11'b0, busy}, 12'd0);
        done_clr = 1'b0;
        chk("R2 first access is count read", acc0_a, LOC_C);
        chk("R2 second access is address read", acc1_a, LOC_A);
        chk("R2 both initial accesses are reads", {10'b0, acc0_w, acc1_w}, 12'd0);
        chk("R5 R8 words moved", 12'(k), 12'(n));
        chk("R9 access count", 12'(n_acc), 12'(n + 4));
        chk("R6 count word written back", mem[LOC_C], 12'd0);
        chk("R6 address word written back", mem[LOC_A], 12'(adr + n));
        chk("R6 count written before address", wprev_a, LOC_C);
        chk("R6 address written last", wlast_a, LOC_A);
        if (to_mem) begin
            for (int i = 1; i <= n; i++)
                chk("R3 R10 memory word from device", mem[12'(adr + i)], pat(i));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset busy", {11'b0, busy}, 12'd0);
        chk("R1 reset flag", {11'b0, done_flag}, 12'd0);
        chk("R1 reset requests", {9'b0, mem_rd_req, mem_wr_req, dev_req}, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {9'b0, mem_rd_req, mem_wr_req, dev_req}, 12'd0);

        run(1'b1, 12'o7773, 12'o0077, 1'b0, 1'b0);   // 5 words to memory
        repeat (3) @(negedge clk);
        chk("R7 flag held without clear", {11'b0, done_flag}, 12'd1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R7 flag cleared", {11'b0, done_flag}, 12'd0);

        run(1'b0, 12'o7771, 12'o1777, 1'b0, 1'b0);   // 7 words to device
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        run(1'b1, 12'o7777, 12'o0500, 1'b0, 1'b1);   // 1 word, clear held: set wins
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        run(1'b1, 12'o7774, 12'o7775, 1'b0, 1'b0);   // R10 wrap past 7777
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        run(1'b0, 12'o7772, 12'o0200, 1'b1, 1'b0);   // R8 starts while busy
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        run(1'b1, 12'o7772, 12'o0300, 1'b1, 1'b0);   // R8 other direction
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        run(1'b0, 12'o0000, 12'o7777, 1'b0, 1'b0);   // R5 zero count: 4096 words

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule